// File: doc/BRIEF.md
# Burst Memory Target with Registered Acknowledge

This block is a small on-chip memory that answers a shared-bus master through a fully registered acknowledge. Besides the address, the master sends a three-bit cycle-type tag and a two-bit wrap code with every beat. The tag says whether another beat follows, and if so how its address is formed. With that hint the target predicts the next address and loads the next read word on the same edge that completes the current beat. Its acknowledge can therefore stay high from beat to beat without waiting to sample the strobe. A zero-wait burst of N beats takes N+1 clocks. Plain single transfers take two clocks each.

The sequencer has three named states. In IDLE the acknowledge is low. In SINGLE a one-shot transfer is acknowledged. In BURST beats keep flowing with the acknowledge held high. The transitions are:
- IDLE to SINGLE on a request whose tag cannot continue.
- IDLE to BURST on a request tagged constant or incrementing with a supported wrap.
- SINGLE to IDLE once the beat completes or the cycle line falls.
- BURST to BURST on a continuing beat or a master wait.
- BURST to IDLE on a beat with any non-continuing tag, or when the cycle line falls.

Writes honour per-byte lane selects. Address and data widths are parameters. The memory holds 2^AW words and is addressed by word.

Top module: `rfb_burst_target`

## Requirements
- R1: Tag 000 (single transfer): the acknowledge rises one clock after a request is seen with the acknowledge low, and falls on the clock after the beat completes. Back-to-back single transfers take two clocks each.
- R2: Tag 111 (last beat): the beat carrying it completes normally and the acknowledge is low on the next clock. A lone request tagged 111 takes two clocks.
- R3: Tags 001 (constant address) and 010 (incrementing): after each completed beat the acknowledge stays high, and the next beat's read word appears on that same edge. A zero-wait burst of N beats, the last tagged 111, completes in N+1 clocks.
- R4: The next word address is unchanged for tag 001. For tag 010 it depends on the wrap code: code 00 is address+1 modulo 2^AW; codes 01, 10 and 11 increment only the low 2, 3 or 4 address bits, modulo 4, 8 or 16 (wrap-4 from 18 gives 18,19,16,17).
- R5: A beat is committed (write stored, read word consumed) only on an edge where the acknowledge, the strobe and the cycle line are all high. The acknowledge may be high while the strobe is low.
- R6: While the master holds the strobe low in the middle of a burst, the acknowledge, the presented read word and the predicted address are all held until the strobe returns.
- R7: Reserved tags 011 to 110, and wrap code 11 when WRAP16_EN is 0, are handled exactly as tag 000.
- R8: On a write, byte lane i (bits 8i+7..8i) is stored only when select bit i is 1. Other lanes keep their contents.
- R9: With the cycle line low, the acknowledge is low from the next clock and nothing is written, whatever the strobe does.
- R10: While reset is asserted, the acknowledge and the read data output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Beat request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | AW | Word address |
| sel_i | input | DW/8 | Byte lane selects |
| dat_i | input | DW | Write data |
| ctype_i | input | 3 | Cycle-type tag (000 single, 001 constant, 010 incrementing, 111 last) |
| wrap_i | input | 2 | Wrap code for incrementing bursts (00 linear, 01/10/11 wrap 4/8/16) |
| ack_o | output | 1 | Registered acknowledge |
| dat_o | output | DW | Registered read data |

## Verification
The properties assume a master that keeps operation, selects and the address sequence constant or stepped exactly as its tag announces, so a burst read is only checked against the words the master itself asked for. They also assume the tag seen on a completing beat truly describes whether another beat follows. The stimulus keeps within this in two ways. Every burst vector computes its addresses from the tag and wrap rules, and ends with a 111 beat. Only the directed tests break the flow, and they do so by lowering the strobe or the cycle line, never by presenting an inconsistent address mid-burst.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    localparam logic [2:0] TAG_SINGLE = 3'b000;
    localparam logic [2:0] TAG_CONST  = 3'b001;
    localparam logic [2:0] TAG_INCR   = 3'b010;
    localparam logic [2:0] TAG_LAST   = 3'b111;

    localparam logic [1:0] WRAP_LIN = 2'b00;
    localparam logic [1:0] WRAP_4   = 2'b01;
    localparam logic [1:0] WRAP_8   = 2'b10;
    localparam logic [1:0] WRAP_16  = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_BURST  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/rfb_addr_step.sv
module rfb_addr_step
    import rfb_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [AW-1:0] cur_i,
    input  logic [2:0]    ctype_i,
    input  logic [1:0]    wrap_i,
    output logic [AW-1:0] nxt_o
);

    localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};
    localparam logic [AW-1:0] MASK4    = AW'(3);
    localparam logic [AW-1:0] MASK8    = AW'(7);
    localparam logic [AW-1:0] MASK16   = AW'(15);

    logic [AW-1:0] mask;
    logic [AW-1:0] inc;

    always_comb begin
        unique case (wrap_i)
            WRAP_4:  mask = MASK4;
            WRAP_8:  mask = MASK8;
            WRAP_16: mask = MASK16;
            default: mask = ALL_ONES;
        endcase
        inc = cur_i + AW'(1);
        if (ctype_i == TAG_CONST) begin
            nxt_o = cur_i;
        end else begin
            nxt_o = (cur_i & ~mask) | (inc & mask);
        end
    end

endmodule

// File: rtl/rfb_lane_mem.sv
module rfb_lane_mem #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            we_i,
    input  logic [AW-1:0]   waddr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [DW/8-1:0] wsel_i,
    input  logic [AW-1:0]   raddr_i,
    output logic [DW-1:0]   rdata_o
);

    localparam int LANES = DW / 8;
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i && wsel_i[g]) begin
                bank[waddr_i] <= wdata_i[g*8 +: 8];
            end
        end

        assign rdata_o[g*8 +: 8] = bank[raddr_i];
    end

endmodule

// File: rtl/rfb_seq.sv
module rfb_seq
    import rfb_pkg::*;
#(
    parameter int AW        = 6,
    parameter bit WRAP16_EN = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_i,
    input  logic          stb_i,
    input  logic [2:0]    ctype_i,
    input  logic [1:0]    wrap_i,
    input  logic [AW-1:0] adr_i,
    input  logic [AW-1:0] step_i,
    output logic          ack_o,
    output logic [AW-1:0] cur_adr_o,
    output logic [AW-1:0] rd_adr_o,
    output logic          rd_load_o,
    output logic          wr_fire_o
);

    seq_state_t    state_q;
    seq_state_t    state_d;
    logic          req;
    logic          burst_ok;
    logic          ack_q;
    logic [AW-1:0] adr_q;

    assign req = cyc_i && stb_i;

    // A tag may continue only if it is constant, or incrementing with a wrap we support
    always_comb begin
        burst_ok = 1'b0;
        if (ctype_i == TAG_CONST) begin
            burst_ok = 1'b1;
        end else if (ctype_i == TAG_INCR) begin
            burst_ok = (wrap_i != WRAP_16) || WRAP16_EN;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = burst_ok ? ST_BURST : ST_SINGLE;
                end
            end
            ST_SINGLE: begin
                if (!cyc_i || stb_i) begin
                    state_d = ST_IDLE;
                end
            end
            ST_BURST: begin
                if (!cyc_i) begin
                    state_d = ST_IDLE;
                end else if (stb_i && !burst_ok) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs: acknowledge and beat address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            adr_q <= '0;
        end else begin
            ack_q <= (state_d != ST_IDLE);
            if (state_q == ST_IDLE && req) begin
                adr_q <= adr_i;
            end else if (state_q == ST_BURST && req && burst_ok) begin
                adr_q <= step_i;
            end
        end
    end

    always_comb begin
        rd_load_o = 1'b0;
        rd_adr_o  = step_i;
        if (state_q == ST_IDLE) begin
            rd_adr_o  = adr_i;
            rd_load_o = req;
        end else if (state_q == ST_BURST) begin
            rd_load_o = req && burst_ok;
        end
    end

    assign wr_fire_o = ack_q && req;
    assign ack_o     = ack_q;
    assign cur_adr_o = adr_q;

endmodule

// File: rtl/rfb_burst_target.sv
module rfb_burst_target
    import rfb_pkg::*;
#(
    parameter int AW        = 6,
    parameter int DW        = 32,
    parameter bit WRAP16_EN = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_i,
    input  logic            stb_i,
    input  logic            we_i,
    input  logic [AW-1:0]   adr_i,
    input  logic [DW/8-1:0] sel_i,
    input  logic [DW-1:0]   dat_i,
    input  logic [2:0]      ctype_i,
    input  logic [1:0]      wrap_i,
    output logic            ack_o,
    output logic [DW-1:0]   dat_o
);

    logic [AW-1:0] cur_adr;
    logic [AW-1:0] step_adr;
    logic [AW-1:0] rd_adr;
    logic          rd_load;
    logic          wr_fire;
    logic [DW-1:0] rd_word;

    rfb_addr_step #(.AW(AW)) u_step (
        .cur_i   (cur_adr),
        .ctype_i (ctype_i),
        .wrap_i  (wrap_i),
        .nxt_o   (step_adr)
    );

    rfb_seq #(.AW(AW), .WRAP16_EN(WRAP16_EN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_i     (cyc_i),
        .stb_i     (stb_i),
        .ctype_i   (ctype_i),
        .wrap_i    (wrap_i),
        .adr_i     (adr_i),
        .step_i    (step_adr),
        .ack_o     (ack_o),
        .cur_adr_o (cur_adr),
        .rd_adr_o  (rd_adr),
        .rd_load_o (rd_load),
        .wr_fire_o (wr_fire)
    );

    rfb_lane_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk     (clk),
        .we_i    (wr_fire && we_i),
        .waddr_i (cur_adr),
        .wdata_i (dat_i),
        .wsel_i  (sel_i),
        .raddr_i (rd_adr),
        .rdata_o (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_o <= '0;
        end else if (rd_load) begin
            dat_o <= rd_word;
        end
    end

endmodule

// File: rtl/rfb_burst_target_chk.sv
module rfb_burst_target_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cyc_i,
    input logic          stb_i,
    input logic [2:0]    ctype_i,
    input logic          ack_o,
    input logic [DW-1:0] dat_o
);

    // R1
    req_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_o && cyc_i && stb_i) |=> ack_o);

    // R1
    single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && cyc_i && stb_i && ctype_i == 3'b000) |=> !ack_o);

    // R2
    last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && cyc_i && stb_i && ctype_i == 3'b111) |=> !ack_o);

    // R3
    const_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && cyc_i && stb_i && ctype_i == 3'b001) |=> ack_o);

    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && cyc_i && !stb_i) |=> (ack_o && $stable(dat_o)));

    // R7
    reserved_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && cyc_i && stb_i && ctype_i >= 3'b011 && ctype_i <= 3'b110) |=> !ack_o);

    // R9
    cyc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_i) |=> !ack_o);

endmodule

bind rfb_burst_target rfb_burst_target_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc_i   (cyc_i),
    .stb_i   (stb_i),
    .ctype_i (ctype_i),
    .ack_o   (ack_o),
    .dat_o   (dat_o)
);

// File: tb/tb_rfb_burst_target.sv
module tb_rfb_burst_target;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    typedef struct packed {
        logic       we;
        logic [2:0] ct;
        logic [1:0] wr;
        logic [5:0] st;
        logic [4:0] n;
        logic [3:0] sel;
        logic [7:0] seed;
        logic [5:0] clks;
    } vec_t;

    // we, tag, wrap, start, beats, sel, seed, expected clocks
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 3'b010, 2'b00, 6'd0,  5'd8, 4'hF, 8'h01, 6'd9},
        '{1'b0, 3'b010, 2'b00, 6'd0,  5'd8, 4'hF, 8'h00, 6'd9},
        '{1'b1, 3'b010, 2'b01, 6'd17, 5'd4, 4'hF, 8'h02, 6'd5},
        '{1'b0, 3'b010, 2'b01, 6'd18, 5'd4, 4'hF, 8'h00, 6'd5},
        '{1'b1, 3'b010, 2'b10, 6'd45, 5'd8, 4'hF, 8'h03, 6'd9},
        '{1'b0, 3'b010, 2'b00, 6'd40, 5'd8, 4'hF, 8'h00, 6'd9},
        '{1'b1, 3'b000, 2'b00, 6'd30, 5'd3, 4'hF, 8'h04, 6'd6},
        '{1'b1, 3'b000, 2'b00, 6'd30, 5'd3, 4'h5, 8'h05, 6'd6},
        '{1'b0, 3'b000, 2'b00, 6'd30, 5'd3, 4'hF, 8'h00, 6'd6},
        '{1'b1, 3'b001, 2'b00, 6'd50, 5'd4, 4'hF, 8'h06, 6'd5},
        '{1'b0, 3'b001, 2'b00, 6'd50, 5'd3, 4'hF, 8'h00, 6'd4},
        '{1'b1, 3'b111, 2'b00, 6'd60, 5'd1, 4'hF, 8'h07, 6'd2},
        '{1'b0, 3'b111, 2'b00, 6'd60, 5'd1, 4'hF, 8'h00, 6'd2},
        '{1'b1, 3'b011, 2'b00, 6'd20, 5'd2, 4'hF, 8'h08, 6'd4},
        '{1'b0, 3'b110, 2'b00, 6'd20, 5'd2, 4'hF, 8'h00, 6'd4},
        '{1'b1, 3'b010, 2'b11, 6'd14, 5'd3, 4'hF, 8'h09, 6'd6},
        '{1'b0, 3'b010, 2'b00, 6'd14, 5'd2, 4'hF, 8'h00, 6'd3},
        '{1'b0, 3'b000, 2'b00, 6'd0,  5'd1, 4'hF, 8'h00, 6'd2},
        '{1'b1, 3'b010, 2'b00, 6'd5,  5'd3, 4'h3, 8'h0A, 6'd4},
        '{1'b0, 3'b010, 2'b00, 6'd5,  5'd3, 4'hF, 8'h00, 6'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0;
    logic        stb = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  adr = '0;
    logic [3:0]  sel = '0;
    logic [31:0] wdat = '0;
    logic [2:0]  ctype = '0;
    logic [1:0]  wrap = '0;
    logic        ack;
    logic [31:0] rdat;

    logic [31:0] mdl [64];
    int n_chk = 0;
    int n_fail = 0;

    rfb_burst_target dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_i   (cyc),
        .stb_i   (stb),
        .we_i    (we),
        .adr_i   (adr),
        .sel_i   (sel),
        .dat_i   (wdat),
        .ctype_i (ctype),
        .wrap_i  (wrap),
        .ack_o   (ack),
        .dat_o   (rdat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input logic [7:0] s, input int k);
        return {s, 8'(k), ~s, 8'h3C ^ 8'(k)};
    endfunction

    function automatic logic [5:0] baddr(input vec_t v, input int k);
        int w;
        int base;
        int off;
        if (v.ct == 3'b001) return v.st;
        if (v.ct == 3'b010) begin
            w = (v.wr == 2'b00) ? 64 : (2 << v.wr);
            base = int'(v.st) - (int'(v.st) % w);
            off = ((int'(v.st) % w) + k) % w;
            return 6'(base + off);
        end
        return 6'(int'(v.st) + k);
    endfunction

    function automatic bit is_burst(input vec_t v);
        return (v.ct == 3'b001) || (v.ct == 3'b010 && v.wr != 2'b11);
    endfunction

    function automatic string lbl_of(input vec_t v);
        if (v.ct == 3'b000) return "R1";
        if (v.ct == 3'b111) return "R2";
        if (v.ct == 3'b001) return "R3";
        if (v.ct == 3'b010 && v.wr != 2'b11) return "R4";
        return "R7";
    endfunction

    task automatic drive_beat(input vec_t v, input int k);
        cyc  = 1'b1;
        stb  = 1'b1;
        we   = v.we;
        adr  = baddr(v, k);
        sel  = v.sel;
        wrap = v.wr;
        if (is_burst(v) || (v.ct == 3'b010)) begin
            ctype = (k == int'(v.n) - 1) ? 3'b111 : v.ct;
        end else begin
            ctype = v.ct;
        end
        wdat = v.we ? pat(v.seed, k) : 32'h0;
    endtask

    task automatic run_vec(input vec_t v);
        int k = 0;
        int clocks = 0;
        int guard = 0;
        bit done;
        logic [5:0] a;
        string lbl;
        lbl = lbl_of(v);
        @(negedge clk);
        drive_beat(v, 0);
        while (k < int'(v.n) && guard < 200) begin
            done = 1'b0;
            if (ack) begin
                done = 1'b1;
                a = baddr(v, k);
                if (!v.we) begin
                    chk(rdat == mdl[a], lbl, rdat, mdl[a]);
                end else begin
                    for (int l = 0; l < 4; l++) begin
                        if (v.sel[l]) mdl[a][l*8 +: 8] = wdat[l*8 +: 8];
                    end
                end
            end
            @(posedge clk);
            clocks++;
            guard++;
            @(negedge clk);
            if (done) begin
                k++;
                if (k < int'(v.n)) begin
                    drive_beat(v, k);
                end else begin
                    cyc = 1'b0;
                    stb = 1'b0;
                    we  = 1'b0;
                end
            end
        end
        if (is_burst(v)) begin
            // R3: N beats in N+1 clocks
            chk(clocks == int'(v.clks), "R3", 32'(clocks), 32'(v.clks));
            // R2: acknowledge low after the last beat
            chk(!ack, "R2", 32'(ack), 32'd0);
        end else begin
            chk(clocks == int'(v.clks), lbl, 32'(clocks), 32'(v.clks));
            chk(!ack, lbl, 32'(ack), 32'd0);
        end
    endtask

    task automatic read_one(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = a; ctype = 3'b000; wrap = 2'b00; sel = 4'hF;
        @(posedge clk);
        @(negedge clk);
        d = rdat;
        chk(ack, "R1", 32'(ack), 32'd1);
        @(posedge clk);
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] p4;
        logic [31:0] p5;
        for (int i = 0; i < 64; i++) mdl[i] = '0;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk(ack == 1'b0, "R10", 32'(ack), 32'd0);
        chk(rdat == 32'h0, "R10", rdat, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack == 1'b0, "R10", 32'(ack), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
            if (i == 8) begin
                // R8: lanes 0 and 2 from the second write, lanes 1 and 3 kept
                p4 = pat(8'h04, 1);
                p5 = pat(8'h05, 1);
                read_one(6'd31, d);
                chk(d == {p4[31:24], p5[23:16], p4[15:8], p5[7:0]}, "R8", d,
                    {p4[31:24], p5[23:16], p4[15:8], p5[7:0]});
            end
        end

        // R6: master wait inside a read burst
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 6'd0; ctype = 3'b010; wrap = 2'b00;
        @(posedge clk); @(negedge clk);
        chk(ack && rdat == mdl[0], "R3", rdat, mdl[0]);
        @(posedge clk); @(negedge clk);
        stb = 1'b0; adr = 6'h3F; ctype = 3'b000;
        chk(ack && rdat == mdl[1], "R6", rdat, mdl[1]);
        for (int w = 0; w < 2; w++) begin
            @(posedge clk); @(negedge clk);
            // R5: acknowledge high with strobe low
            chk(ack, "R5", 32'(ack), 32'd1);
            chk(rdat == mdl[1], "R6", rdat, mdl[1]);
        end
        stb = 1'b1; adr = 6'd1; ctype = 3'b010;
        @(posedge clk); @(negedge clk);
        // R6: predicted address kept through the wait
        chk(ack && rdat == mdl[2], "R6", rdat, mdl[2]);
        adr = 6'd2; ctype = 3'b111;
        @(posedge clk); @(negedge clk);
        chk(!ack, "R2", 32'(ack), 32'd0);
        cyc = 1'b0; stb = 1'b0;

        // R5 / R9: write burst, wait with junk data, then abort
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = 6'd1; ctype = 3'b010; wrap = 2'b00;
        sel = 4'hF; wdat = 32'hA5A5_0101;
        @(posedge clk); @(negedge clk);
        chk(ack, "R1", 32'(ack), 32'd1);
        @(posedge clk); @(negedge clk);
        mdl[1] = 32'hA5A5_0101;
        stb = 1'b0; wdat = 32'hDEAD_BEEF;
        @(posedge clk); @(negedge clk);
        chk(ack, "R5", 32'(ack), 32'd1);
        cyc = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(!ack, "R9", 32'(ack), 32'd0);
        stb = 1'b1; adr = 6'd3;
        @(posedge clk); @(negedge clk);
        chk(!ack, "R9", 32'(ack), 32'd0);
        stb = 1'b0; we = 1'b0;
        read_one(6'd2, d);
        chk(d == mdl[2], "R5", d, mdl[2]);
        read_one(6'd1, d);
        chk(d == mdl[1], "R5", d, mdl[1]);
        read_one(6'd3, d);
        chk(d == mdl[3], "R9", d, mdl[3]);

        // R10: reset in the middle of a burst
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 6'd4; ctype = 3'b010;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(ack == 1'b0, "R10", 32'(ack), 32'd0);
        chk(rdat == 32'h0, "R10", rdat, 32'h0);
        cyc = 1'b0; stb = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack == 1'b0, "R10", 32'(ack), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule